// File: doc/BRIEF.md
# Interrupt Request Latch and Dispatcher

This block watches a bank of interrupt input pins and keeps a pending bit for each one. A separate register file supplies a 64-bit redirection entry for each pin as a flat parallel bus. Whenever a pin rises or the register file reports a write, the block walks the pins from index 0 upward. For each pin that is pending and not masked, it issues one delivery message on a valid/ready output.

Each message carries the destination, destination mode, delivery mode, vector, polarity and trigger mode taken from the pin's entry. When an entry selects the external-interrupt delivery mode, the vector is not taken from the entry. Instead it is fetched from a legacy interrupt controller over a request/acknowledge handshake before the message is offered.

Level pins and edge pins are latched differently. Only edge pins lose their pending bit once their message is accepted.

Top module: `irq_dispatcher`

## Requirements
- R1: After reset all pending bits are clear and the scanner is idle, with `msg_valid` and `legacy_req` low; a rescan started right after reset issues no message.
- R2: Entry field positions: vector bits 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 (1 = level), mask 16, destination 63:56. Each message reproduces these fields of the dispatched pin's entry.
- R3: A pin whose mask bit is 1 is never dispatched, yet its pending bit is kept; clearing the mask with an entry write then dispatches it.
- R4: For a level pin, the pending bit follows the input: high sets it, low clears it, one cycle after the input is sampled.
- R5: For an edge pin, a 0-to-1 transition of the input sets the pending bit, and a low input leaves it unchanged.
- R6: When a message for an edge pin is accepted (`msg_valid` and `msg_ready` both high), that pin's pending bit is cleared. A level pin stays pending after acceptance.
- R7: When the delivery mode equals 3'b111, the block raises `legacy_req` and holds it until `legacy_ack`. The message vector is the `legacy_vector` value sampled with the acknowledge. Only one of `legacy_req` and `msg_valid` is high at a time.
- R8: A scan starts only on a rising pin input or a `redir_wr` pulse. A request that arrives during a scan causes one further full scan.
- R9: Within one scan, pins are dispatched in ascending index order.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and every message field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NPINS | Interrupt input pins |
| redir_flat | input | NPINS*64 | Redirection entries, pin p at bits p*64+63 : p*64 |
| redir_wr | input | 1 | Pulse: an entry was written, start a rescan |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Delivery message accepted when high with valid |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity |
| msg_trigger | output | 1 | Trigger mode, 1 = level |
| legacy_req | output | 1 | Vector fetch request to the legacy controller |
| legacy_ack | input | 1 | Vector fetch acknowledge |
| legacy_vector | input | 8 | Vector returned with the acknowledge |

## Verification
Every pin in turn is configured as an edge pin, with field values computed from its index, and pulsed alone. This shows that each entry slice is routed to the matching message fields and that no pin aliases another.

Pulsing three pins in the same cycle, in scrambled order, shows whether the scan is ascending. A rescan with no new input shows whether an edge pin was cleared while a held level pin stays pending, and whether a low level pin drops out.

A masked pin that is later unmasked separates "never dispatched" from "forgotten". An external-mode pin shows whether the vector comes from the handshake rather than the entry. A stalled output shows whether the fields stay frozen while ready is low.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  localparam int ENT_W = 64;
  localparam logic [2:0] DLV_EXTINT = 3'b111;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] dlv;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } irq_msg_t;

  function automatic logic ent_is_level(input logic [ENT_W-1:0] e);
    return e[15];
  endfunction

  function automatic logic ent_is_masked(input logic [ENT_W-1:0] e);
    return e[16];
  endfunction

  function automatic irq_msg_t ent_to_msg(input logic [ENT_W-1:0] e);
    irq_msg_t m;
    m.dest      = e[63:56];
    m.dest_mode = e[11];
    m.dlv       = e[10:8];
    m.vector    = e[7:0];
    m.polarity  = e[13];
    m.trigger   = e[15];
    return m;
  endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_in,
  input  logic [NPINS-1:0] level_sel,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NPINS-1:0] pend,
  output logic [NPINS-1:0] pin_rise,
  output logic             rise_any
);

  logic [NPINS-1:0] irq_q;

  assign pin_rise = irq_in & ~irq_q;
  assign rise_any = |pin_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic clr_here;
    assign clr_here = clr_valid && (clr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)            pend[g] <= 1'b0;
      else if (level_sel[g]) pend[g] <= irq_in[g];
      else if (pin_rise[g])  pend[g] <= 1'b1;
      else if (clr_here)     pend[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_scan_fsm.sv
module irq_scan_fsm
  import irq_dispatch_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [NPINS-1:0] pend,
  input  logic [NPINS-1:0] mask_bits,
  input  logic [ENT_W-1:0] ent [NPINS],
  input  logic             msg_ready,
  input  logic             legacy_ack,
  input  logic [7:0]       legacy_vector,
  output logic             msg_valid,
  output irq_msg_t         msg,
  output logic             legacy_req,
  output logic [IDX_W-1:0] cur_idx,
  output logic             disp_start,
  output logic             clr_valid
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FETCH, S_SEND} state_t;

  state_t     state;
  logic       rescan;
  logic       last_pin;
  logic       more;
  logic       hit;
  logic       accept;
  irq_msg_t   cand;

  assign cand       = ent_to_msg(ent[cur_idx]);
  assign last_pin   = (cur_idx == IDX_W'(NPINS - 1));
  assign more       = rescan || trig;
  assign hit        = pend[cur_idx] && !mask_bits[cur_idx];
  assign disp_start = (state == S_SCAN) && hit;
  assign accept     = (state == S_SEND) && msg_ready;
  assign clr_valid  = accept && !msg.trigger;
  assign msg_valid  = (state == S_SEND);
  assign legacy_req = (state == S_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rescan  <= 1'b0;
      cur_idx <= '0;
      msg     <= '0;
    end else begin
      if (trig) rescan <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (more) begin
            state   <= S_SCAN;
            cur_idx <= '0;
            rescan  <= 1'b0;
          end
        end
        S_SCAN: begin
          if (hit) begin
            msg   <= cand;
            state <= (cand.dlv == DLV_EXTINT) ? S_FETCH : S_SEND;
          end else if (!last_pin) begin
            cur_idx <= cur_idx + 1'b1;
          end else if (more) begin
            cur_idx <= '0;
            rescan  <= 1'b0;
          end else begin
            state <= S_IDLE;
          end
        end
        S_FETCH: begin
          if (legacy_ack) begin
            msg.vector <= legacy_vector;
            state      <= S_SEND;
          end
        end
        S_SEND: begin
          if (msg_ready) begin
            if (!last_pin) begin
              state   <= S_SCAN;
              cur_idx <= cur_idx + 1'b1;
            end else if (more) begin
              state   <= S_SCAN;
              cur_idx <= '0;
              rescan  <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_dispatcher.sv
module irq_dispatcher
  import irq_dispatch_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   irq_in,
  input  logic [NPINS*64-1:0] redir_flat,
  input  logic               redir_wr,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_dest,
  output logic               msg_dest_mode,
  output logic [2:0]         msg_dlv_mode,
  output logic [7:0]         msg_vector,
  output logic               msg_polarity,
  output logic               msg_trigger,
  output logic               legacy_req,
  input  logic               legacy_ack,
  input  logic [7:0]         legacy_vector
);

  logic [ENT_W-1:0] ent [NPINS];
  logic [NPINS-1:0] level_sel;
  logic [NPINS-1:0] mask_bits;
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] pin_rise;
  logic             rise_any;
  logic             trig;
  logic             clr_valid;
  logic             disp_start;
  logic [IDX_W-1:0] cur_idx;
  irq_msg_t         msg;

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    assign ent[g]       = redir_flat[g*ENT_W +: ENT_W];
    assign level_sel[g] = ent_is_level(ent[g]);
    assign mask_bits[g] = ent_is_masked(ent[g]);
  end

  assign trig = rise_any || redir_wr;

  irq_pend_latch #(.NPINS(NPINS)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .level_sel (level_sel),
    .clr_valid (clr_valid),
    .clr_idx   (cur_idx),
    .pend      (pend),
    .pin_rise  (pin_rise),
    .rise_any  (rise_any)
  );

  irq_scan_fsm #(.NPINS(NPINS)) u_scan (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig          (trig),
    .pend          (pend),
    .mask_bits     (mask_bits),
    .ent           (ent),
    .msg_ready     (msg_ready),
    .legacy_ack    (legacy_ack),
    .legacy_vector (legacy_vector),
    .msg_valid     (msg_valid),
    .msg           (msg),
    .legacy_req    (legacy_req),
    .cur_idx       (cur_idx),
    .disp_start    (disp_start),
    .clr_valid     (clr_valid)
  );

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_dlv_mode  = msg.dlv;
  assign msg_vector    = msg.vector;
  assign msg_polarity  = msg.polarity;
  assign msg_trigger   = msg.trigger;

endmodule

// File: rtl/irq_dispatcher_chk.sv
module irq_dispatcher_chk #(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] irq_in,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] pin_rise,
  input logic [NPINS-1:0] level_sel,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [21:0]      fields,
  input logic             legacy_req,
  input logic             legacy_ack,
  input logic             clr_valid,
  input logic [IDX_W-1:0] cur_idx
);

  // R10: stalled message keeps valid and fields
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(fields)));

  // R7: fetch request held until acknowledged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_req && !legacy_ack) |=> legacy_req);

  // R7: fetch and offer never overlap
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({legacy_req, msg_valid}));

  // R4: level pins mirror the sampled input
  a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend ^ $past(irq_in)) & $past(level_sel)) == '0));

  // R5: a rising edge pin becomes pending
  a_r5_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pin_rise & ~level_sel) & ~pend) == '0));

  // R6: accepted edge pin is cleared unless it rose again
  a_r6_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !pin_rise[cur_idx] && !level_sel[cur_idx])
      |=> !pend[$past(cur_idx)]);

endmodule

bind irq_dispatcher irq_dispatcher_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_in     (irq_in),
  .pend       (pend),
  .pin_rise   (pin_rise),
  .level_sel  (level_sel),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .fields     ({msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector,
                msg_polarity, msg_trigger}),
  .legacy_req (legacy_req),
  .legacy_ack (legacy_ack),
  .clr_valid  (clr_valid),
  .cur_idx    (cur_idx)
);

// File: tb/irq_dispatcher_tb.sv
module irq_dispatcher_tb;

  localparam int NP = 24;
  localparam logic [7:0] LEG_VEC = 8'hC8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] irq_in = '0;
  logic [NP*64-1:0] redir_flat = '0;
  logic redir_wr = 1'b0;
  logic msg_valid, msg_ready = 1'b0;
  logic [7:0] msg_dest, msg_vector;
  logic msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0] msg_dlv_mode;
  logic legacy_req, legacy_ack;
  logic [7:0] legacy_vector;

  int checks = 0;
  int errors = 0;
  int legacy_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_dispatcher #(.NPINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .redir_flat(redir_flat),
    .redir_wr(redir_wr), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode),
    .msg_dlv_mode(msg_dlv_mode), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger),
    .legacy_req(legacy_req), .legacy_ack(legacy_ack),
    .legacy_vector(legacy_vector)
  );

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dm, input logic pol, input logic lvl, input logic msk,
      input logic [7:0] dst);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dlv; e[11] = dm; e[13] = pol;
    e[15] = lvl; e[16] = msk; e[63:56] = dst;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ent(input int p, input logic [63:0] e);
    @(negedge clk);
    redir_flat[p*64 +: 64] = e;
    redir_wr = 1'b1;
    @(negedge clk);
    redir_wr = 1'b0;
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  // waits for an offered message, samples it, accepts it
  task automatic get_msg(output bit got, output logic [21:0] f);
    got = 0; f = '0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1;
        f = {msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector, msg_polarity, msg_trigger};
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
      end
    end
  endtask

  task automatic expect_none(input string tag);
    bit seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        seen = 1;
        msg_ready = 1'b1;
      end else msg_ready = 1'b0;
    end
    msg_ready = 1'b0;
    chk(!seen, tag, seen, 0);
  endtask

  function automatic logic [21:0] fexp(input logic [63:0] e, input logic [7:0] vec);
    return {e[63:56], e[11], e[10:8], vec, e[13], e[15]};
  endfunction

  // legacy controller model: acknowledges after 3 cycles
  initial begin
    int lat = 0;
    legacy_ack = 1'b0;
    legacy_vector = 8'h00;
    forever begin
      @(negedge clk);
      if (legacy_ack) begin
        legacy_ack = 1'b0;
        legacy_vector = 8'h00;
      end else if (legacy_req) begin
        if (lat == 0) legacy_seen++;
        lat++;
        if (lat == 3) begin
          legacy_ack = 1'b1;
          legacy_vector = LEG_VEC;
          lat = 0;
        end
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [21:0] f, f0;
    logic [63:0] e;

    for (int p = 0; p < NP; p++) redir_flat[p*64 +: 64] = mk(8'h00, 3'd0, 0, 0, 0, 1, 8'h00);
    repeat (4) @(negedge clk);
    chk(msg_valid == 0 && legacy_req == 0, "R1 reset outputs", {msg_valid, legacy_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < NP; p++) redir_flat[p*64 +: 64] = mk(8'h00, 3'd0, 0, 0, 0, 0, 8'h00);
    redir_wr = 1'b1;
    @(negedge clk);
    redir_wr = 1'b0;
    expect_none("R1 nothing pending after reset");

    // R2 R5 R6: sweep every pin as an edge pin
    for (int p = 0; p < NP; p++) begin
      e = mk(8'(8'h20 + p*3), 3'(p % 7), p[0], p[1], 0, 0, 8'(p*7) ^ 8'h5A);
      set_ent(p, e);
      repeat (40) @(negedge clk);
      pulse(NP'(1) << p);
      get_msg(got, f);
      chk(got && f == fexp(e, e[7:0]), $sformatf("R2 R5 fields pin %0d", p), f, fexp(e, e[7:0]));
    end
    set_ent(0, mk(8'h20, 3'd0, 0, 0, 0, 0, 8'h5A));
    expect_none("R6 edge pins cleared after accept");

    // R8: no trigger, no message
    expect_none("R8 idle without trigger");

    // R4 R6: level pin 9
    e = mk(8'h99, 3'd1, 1, 1, 1, 0, 8'h33);
    set_ent(9, e);
    @(negedge clk); irq_in[9] = 1'b1;
    get_msg(got, f);
    chk(got && f == fexp(e, 8'h99), "R4 level dispatch", f, fexp(e, 8'h99));
    set_ent(0, mk(8'h20, 3'd0, 0, 0, 0, 0, 8'h5A));
    get_msg(got, f);
    chk(got && f == fexp(e, 8'h99), "R6 level stays pending", f, fexp(e, 8'h99));
    @(negedge clk); irq_in[9] = 1'b0;
    repeat (40) @(negedge clk);
    set_ent(0, mk(8'h20, 3'd0, 0, 0, 0, 0, 8'h5A));
    expect_none("R4 level low clears pending");
    set_ent(9, mk(8'h99, 3'd1, 0, 0, 0, 0, 8'h33));

    // R3: masked pin kept pending
    e = mk(8'h3C, 3'd2, 0, 1, 0, 1, 8'h81);
    set_ent(3, e);
    repeat (40) @(negedge clk);
    pulse(NP'(1) << 3);
    expect_none("R3 masked pin not dispatched");
    e[16] = 1'b0;
    set_ent(3, e);
    get_msg(got, f);
    chk(got && f == fexp(e, 8'h3C), "R3 unmask dispatches kept pending", f, fexp(e, 8'h3C));

    // R9: ascending order
    for (int p = 0; p < NP; p++) redir_flat[p*64 +: 64] = mk(8'(8'h30 + p), 3'd0, 0, 0, 0, 0, 8'h01);
    set_ent(0, mk(8'h30, 3'd0, 0, 0, 0, 0, 8'h01));
    repeat (40) @(negedge clk);
    pulse((NP'(1) << 20) | (NP'(1) << 2) | (NP'(1) << 11));
    get_msg(got, f);
    chk(got && f[9:2] == 8'h32, "R9 first pin 2", f[9:2], 8'h32);
    get_msg(got, f);
    chk(got && f[9:2] == 8'h3B, "R9 second pin 11", f[9:2], 8'h3B);
    get_msg(got, f);
    chk(got && f[9:2] == 8'h44, "R9 third pin 20", f[9:2], 8'h44);

    // R7: external-interrupt vector
    e = mk(8'h11, 3'b111, 1, 0, 0, 0, 8'hE2);
    set_ent(7, e);
    repeat (40) @(negedge clk);
    pulse(NP'(1) << 7);
    get_msg(got, f);
    chk(got && f == fexp(e, LEG_VEC), "R7 vector from legacy", f, fexp(e, LEG_VEC));
    chk(legacy_seen == 1, "R7 one fetch", legacy_seen, 1);

    // R10: backpressure
    e = mk(8'h66, 3'd4, 1, 1, 0, 0, 8'h77);
    set_ent(6, e);
    repeat (40) @(negedge clk);
    pulse(NP'(1) << 6);
    for (int i = 0; i < 200 && !msg_valid; i++) @(negedge clk);
    f0 = {msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector, msg_polarity, msg_trigger};
    begin
      bit stable = 1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!msg_valid || {msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector,
            msg_polarity, msg_trigger} != f0) stable = 0;
      end
      chk(stable && f0 == fexp(e, 8'h66), "R10 stall holds message", f0, fexp(e, 8'h66));
    end
    get_msg(got, f);
    expect_none("R10 single message after stall");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule